// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the status word of a small processor core. Each instruction that touches the arithmetic flags presents its result bus, carry-out and overflow to the block. The decoder supplies a separate update enable for each arithmetic flag. Carry, zero, sign and overflow are then captured at the next clock edge. Zero and sign are worked out over either the low byte or the full result, as the operand size selects.

The control bits have their own path. Single-step debug, register bank select and stack pointer select change only through a full-register write port, which software uses to load the whole status word. While the debug bit is set, each completed instruction raises a single-step interrupt request. That request stays up until the interrupt is acknowledged. The acknowledge also clears the debug bit, so the handler does not step itself.

Top module: `flagReg`

## Requirements
- R1: A low `rstN` clears all eleven bits of `flags` and drops `stepReq`. Both are zero in the first cycle after reset.
- R2: When `updEn[0]` is high and `wrEn` is low, `flags[0]` (carry) takes `aluCarry` at the next edge.
- R3: When `updEn[1]` is high and `wrEn` is low, `flags[2]` (zero) becomes 1 at the next edge if the result bits in use are all zero, and 0 otherwise. With `wideOp`=0 the bits in use are `aluResult[7:0]`; with `wideOp`=1 they are all 16 bits.
- R4: When `updEn[2]` is high and `wrEn` is low, `flags[3]` (sign) takes `aluResult[7]` if `wideOp`=0, or `aluResult[15]` if `wideOp`=1, at the next edge.
- R5: When `updEn[3]` is high and `wrEn` is low, `flags[5]` (overflow) takes `aluOverflow` at the next edge.
- R6: An arithmetic flag whose `updEn` bit is low keeps its value, whatever the result bus, carry and overflow inputs carry.
- R7: When `wrEn` is high, `flags` is loaded from `wrData` at the next edge and every `updEn` bit is ignored in that cycle. Bit 1 is debug, bit 4 is bank select and bit 7 is stack select.
- R8: Bit positions 6, 8, 9 and 10 of `flags` always read as zero, even when `wrData` sets them.
- R9: When `instrDone` is high while `flags[1]` is 1, `stepReq` rises at the next edge and holds until an acknowledge. When `flags[1]` is 0, `instrDone` does not raise it.
- R10: A high `intAck` clears `flags[1]` and `stepReq` at the next edge. This holds even when the same cycle's `wrEn` writes a 1 to the debug bit or `instrDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| updEn | input | 4 | Update enables: [0] carry, [1] zero, [2] sign, [3] overflow |
| wideOp | input | 1 | Operand size: 0 = 8 bit, 1 = 16 bit |
| aluResult | input | 16 | Result bus from the ALU |
| aluCarry | input | 1 | Carry, borrow or shift-out bit from the ALU |
| aluOverflow | input | 1 | Arithmetic overflow from the ALU |
| wrEn | input | 1 | Full-register write strobe |
| wrData | input | 11 | Value for the full-register write |
| intAck | input | 1 | Single-step interrupt acknowledge |
| instrDone | input | 1 | An instruction completes in this cycle |
| flags | output | 11 | Current status word |
| stepReq | output | 1 | Single-step interrupt request |

## Verification
Every result of this block comes from exactly one register stage. Flag captures, full writes, the debug clear and the rise or fall of `stepReq` all show up on the outputs one clock edge after the stimulus cycle. The bench changes inputs on the falling edge and lets one rising edge pass. It reads `flags` and `stepReq` on the following falling edge, then removes the stimulus. To check that `stepReq` is held, the bench waits one more idle edge with no stimulus and reads it again.

// File: rtl/flagPkg.sv
package flagPkg;
  localparam int FLAG_W = 11;
  localparam int UPD_W  = 4;

  // bit positions inside the status word
  localparam int C_BIT = 0;
  localparam int D_BIT = 1;
  localparam int Z_BIT = 2;
  localparam int S_BIT = 3;
  localparam int B_BIT = 4;
  localparam int O_BIT = 5;
  localparam int U_BIT = 7;

  // positions inside the update-enable vector
  localparam int UPD_C = 0;
  localparam int UPD_Z = 1;
  localparam int UPD_S = 2;
  localparam int UPD_O = 3;

  localparam logic [FLAG_W-1:0] LIVE_MASK =
    FLAG_W'((1 << C_BIT) | (1 << D_BIT) | (1 << Z_BIT) | (1 << S_BIT) |
            (1 << B_BIT) | (1 << O_BIT) | (1 << U_BIT));

  typedef struct packed {
    logic loadAll;
    logic setCarry;
    logic setZero;
    logic setSign;
    logic setOvf;
    logic clrDebug;
  } flagStrobes_t;
endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import flagPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [UPD_W-1:0] updEn,
  input  logic             wrEn,
  input  logic             intAck,
  input  logic             instrDone,
  input  logic             debugBit,
  output flagStrobes_t     strobes,
  output logic             stepReq
);
  logic stepQ;
  logic stepNext;

  always_comb begin
    strobes          = '0;
    strobes.loadAll  = wrEn;
    strobes.setCarry = updEn[UPD_C] & ~wrEn;
    strobes.setZero  = updEn[UPD_Z] & ~wrEn;
    strobes.setSign  = updEn[UPD_S] & ~wrEn;
    strobes.setOvf   = updEn[UPD_O] & ~wrEn;
    strobes.clrDebug = intAck;
  end

  always_comb begin
    stepNext = stepQ | (instrDone & debugBit);
    if (intAck) stepNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= 1'b0;
    else       stepQ <= stepNext;
  end

  assign stepReq = stepQ;
endmodule

// File: rtl/flagPath.sv
module flagPath
  import flagPkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strobes,
  input  logic              wideOp,
  input  logic [RES_W-1:0]  aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] flagsQ
);
  logic [FLAG_W-1:0] nextFlags;
  logic zeroNarrow;
  logic zeroWide;
  logic zeroSel;
  logic signSel;

  assign zeroNarrow = ~|aluResult[NARROW_W-1:0];
  assign zeroWide   = ~|aluResult;
  assign zeroSel    = wideOp ? zeroWide : zeroNarrow;
  assign signSel    = wideOp ? aluResult[RES_W-1] : aluResult[NARROW_W-1];

  always_comb begin
    nextFlags = flagsQ;
    if (strobes.loadAll) begin
      nextFlags = wrData;
    end else begin
      if (strobes.setCarry) nextFlags[C_BIT] = aluCarry;
      if (strobes.setZero)  nextFlags[Z_BIT] = zeroSel;
      if (strobes.setSign)  nextFlags[S_BIT] = signSel;
      if (strobes.setOvf)   nextFlags[O_BIT] = aluOverflow;
    end
    if (strobes.clrDebug) nextFlags[D_BIT] = 1'b0;
    nextFlags = nextFlags & LIVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= nextFlags;
  end
endmodule

// File: rtl/flagReg.sv
module flagReg
  import flagPkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [UPD_W-1:0]  updEn,
  input  logic              wideOp,
  input  logic [RES_W-1:0]  aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] wrData,
  input  logic              intAck,
  input  logic              instrDone,
  output logic [FLAG_W-1:0] flags,
  output logic              stepReq
);
  flagStrobes_t strobes;
  logic [FLAG_W-1:0] flagsQ;

  flagCtrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .updEn     (updEn),
    .wrEn      (wrEn),
    .intAck    (intAck),
    .instrDone (instrDone),
    .debugBit  (flagsQ[D_BIT]),
    .strobes   (strobes),
    .stepReq   (stepReq)
  );

  flagPath #(.RES_W(RES_W), .NARROW_W(NARROW_W)) path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wideOp      (wideOp),
    .aluResult   (aluResult),
    .aluCarry    (aluCarry),
    .aluOverflow (aluOverflow),
    .wrData      (wrData),
    .flagsQ      (flagsQ)
  );

  assign flags = flagsQ;
endmodule

// File: rtl/flagRegChecker.sv
module flagRegChecker
  import flagPkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [UPD_W-1:0]  updEn,
  input logic              wideOp,
  input logic [RES_W-1:0]  aluResult,
  input logic              aluCarry,
  input logic              aluOverflow,
  input logic              wrEn,
  input logic [FLAG_W-1:0] wrData,
  input logic              intAck,
  input logic              instrDone,
  input logic [FLAG_W-1:0] flags,
  input logic              stepReq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (flags == '0 && !stepReq));

  // R2
  carry_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn[UPD_C] && !wrEn) |=> flags[C_BIT] == $past(aluCarry));

  // R3
  zero_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn[UPD_Z] && !wrEn) |=> flags[Z_BIT] ==
      $past(wideOp ? (aluResult == '0) : (aluResult[NARROW_W-1:0] == '0)));

  // R4
  sign_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn[UPD_S] && !wrEn) |=> flags[S_BIT] ==
      $past(wideOp ? aluResult[RES_W-1] : aluResult[NARROW_W-1]));

  // R5
  ovf_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn[UPD_O] && !wrEn) |=> flags[O_BIT] == $past(aluOverflow));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn == '0 && !wrEn && !intAck) |=> $stable(flags));

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !intAck) |=> flags == ($past(wrData) & LIVE_MASK));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~LIVE_MASK) == '0);

  // R9
  step_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && flags[D_BIT] && !intAck) |=> stepReq);

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !intAck) |=> stepReq);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> (!flags[D_BIT] && !stepReq));
endmodule

bind flagReg flagRegChecker #(.RES_W(RES_W), .NARROW_W(NARROW_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .updEn       (updEn),
  .wideOp      (wideOp),
  .aluResult   (aluResult),
  .aluCarry    (aluCarry),
  .aluOverflow (aluOverflow),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .intAck      (intAck),
  .instrDone   (instrDone),
  .flags       (flags),
  .stepReq     (stepReq)
);

// File: tb/flagReg_test.sv
`timescale 1ns/1ps
module flagReg_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  updEn;
  logic        wideOp;
  logic [15:0] aluResult;
  logic        aluCarry;
  logic        aluOverflow;
  logic        wrEn;
  logic [10:0] wrData;
  logic        intAck;
  logic        instrDone;
  logic [10:0] flags;
  logic        stepReq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  flagReg uut (
    .clk(clk), .rstN(rstN), .updEn(updEn), .wideOp(wideOp),
    .aluResult(aluResult), .aluCarry(aluCarry), .aluOverflow(aluOverflow),
    .wrEn(wrEn), .wrData(wrData), .intAck(intAck), .instrDone(instrDone),
    .flags(flags), .stepReq(stepReq)
  );

  // {updEn, wideOp, aluResult, aluCarry, aluOverflow, expected flags}
  localparam logic [33:0] VEC [7] = '{
    {4'b1111, 1'b0, 16'h0100, 1'b1, 1'b0, 11'h005},
    {4'b1111, 1'b1, 16'h8000, 1'b0, 1'b1, 11'h028},
    {4'b0001, 1'b0, 16'h0000, 1'b1, 1'b0, 11'h029},
    {4'b1110, 1'b0, 16'h0080, 1'b0, 1'b0, 11'h009},
    {4'b0000, 1'b0, 16'h0000, 1'b0, 1'b1, 11'h009},
    {4'b0110, 1'b1, 16'h0080, 1'b0, 1'b0, 11'h001},
    {4'b0110, 1'b0, 16'hFF00, 1'b0, 1'b0, 11'h005}
  };

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    updEn = '0; wideOp = 0; aluResult = '0; aluCarry = 0; aluOverflow = 0;
    wrEn = 0; wrData = '0; intAck = 0; instrDone = 0;
  endtask

  // inputs already set at a falling edge; pass one rising edge, land on next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=below 5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 flags", flags, 11'h000);
    check("R1 stepReq", {10'b0, stepReq}, 11'h000);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 7; i++) begin
      {updEn, wideOp, aluResult, aluCarry, aluOverflow} = VEC[i][33:11];
      step();
      check($sformatf("R2/R3/R4/R5/R6 vec%0d", i), flags, VEC[i][10:0]);
      idle();
    end

    // R7 + R8: full write, unused bits masked
    wrEn = 1; wrData = 11'h7FF;
    step();
    check("R7/R8 full write", flags, 11'h0BF);
    idle();

    // R7: write beats ALU update in same cycle
    wrEn = 1; wrData = 11'h000; updEn = 4'b1111; aluResult = 16'h0000; aluCarry = 1; aluOverflow = 1;
    step();
    check("R7 write priority", flags, 11'h000);
    idle();

    // R9: set debug, then instruction completes
    wrEn = 1; wrData = 11'h002;
    step();
    check("R7 debug write", flags, 11'h002);
    idle();
    check("R9 no request yet", {10'b0, stepReq}, 11'h000);
    instrDone = 1;
    step();
    check("R9 request raised", {10'b0, stepReq}, 11'h001);
    idle();
    step();
    check("R9 request held", {10'b0, stepReq}, 11'h001);

    // R10: acknowledge clears debug and request
    intAck = 1;
    step();
    check("R10 debug cleared", flags, 11'h000);
    check("R10 request cleared", {10'b0, stepReq}, 11'h000);
    idle();

    // R9: debug off, no request
    instrDone = 1;
    step();
    check("R9 no request debug off", {10'b0, stepReq}, 11'h000);
    idle();

    // R10: ack overrides debug write; bank and stack bits kept
    wrEn = 1; wrData = 11'h092; intAck = 1;
    step();
    check("R10 ack over write", flags, 11'h090);
    idle();

    // R1: mid-run reset
    wrEn = 1; wrData = 11'h0BF;
    step();
    idle();
    rstN = 0;
    step();
    rstN = 1;
    check("R1 reset mid-run", flags, 11'h000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule